// File: doc/BRIEF.md
# Option Word Guard and Reload Unit

This unit keeps the option configuration of a flash controller. A small non-volatile image of sixteen slots holds, for each slot, a 32-bit value together with a second word that should be its bitwise inverse. A set of live option registers is filled from that image. The first seven slots are writable by software: user options, start and end of two protected code ranges, and two write-protect areas. Slots 7 to 12 are unused, and slots 13 to 15 are loaded but cannot be written by software.

Software reaches the options through two nested locks. The main lock opens with one key pair. The option lock opens with a second key pair, and only while the main lock is open. With both locks open, software edits live registers, commits them into the image with a start bit, or forces a reload of the whole image into the live registers. A reload checks every value/inverse pair. A broken pair raises a validity flag and leaves that register at all ones. A reload also runs on its own after reset.

Register map on the 3-bit word address. 0 CTRL: write bit0 sets the main lock, bit1 sets the option lock, bit2 starts a commit, bit3 starts a reload; read bit0 gives the main lock and bit1 the option lock. 1 STAT: read bit0 busy, bit1 validity error, bit2 slot error; writing 1 to bit1 or bit2 clears that flag. 2 main key. 3 option key. 4 slot select (low 4 bits). 5 live register of the selected slot. 6 stored value word of the selected slot. 7 stored inverse word of the selected slot.

Top module: `opt_lock_load_unit`

## Requirements
- R1: Reset sets both locks. From reset, busy stays high while all slots are read. Busy falls NUM_SLOTS+1 cycles after reset is released. Each live register then holds its stored value. The image starts with value INIT_SEED ^ (i * 32'h11111111) for slot i.
- R2: The main lock clears only when 32'h45670123 and then 32'hCDEF89AB are written back to back to the main key address. Any other value restarts the sequence.
- R3: Option key writes (32'h08192A3B, then 32'h4C5D6E7F) clear the option lock only while the main lock is open. While the main lock is set, they have no effect.
- R4: Writing 1 to CTRL bit0 sets the main lock and the option lock. Writing 1 to CTRL bit1 sets only the option lock.
- R5: With the option lock open and the unit idle, a write to address 5 updates the live register of a selected slot in 0..6. The new value reads back, and it appears on opt_live_o at bits [32*slot +: 32].
- R6: A write to address 5 that selects slot 7..15 leaves the register unchanged and sets the slot error flag. A write to address 5 while the option lock is set changes nothing and raises no flag.
- R7: A commit request (CTRL bit2) is accepted only when the option lock is open, the unit is idle and op_suspended_i is low. Once accepted, it stores each writable slot as its live value with the inverse word beside it, and holds busy for NUM_WR+COMMIT_CYCLES cycles.
- R8: A reload request (CTRL bit3) with the option lock open holds busy for NUM_SLOTS+1 cycles and rewrites every live register from the image. While the option lock is set, a reload request is ignored.
- R9: During a load, a slot whose two stored words are not exact inverses sets the validity error flag and loads 32'hFFFFFFFF into its live register.
- R10: Writing 1 to STAT bit1 or bit2 clears the validity error flag or the slot error flag.
- R11: A single CTRL write that sets the option lock and requests a reload performs the reload, because the lock state before the write applies. The option lock is set afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 3 | Register word address |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, registered, valid the cycle after bus_rd |
| op_suspended_i | input | 1 | A flash operation is suspended; blocks commit |
| busy_o | output | 1 | Commit or load in progress |
| main_lock_o | output | 1 | Main lock state |
| opt_lock_o | output | 1 | Option lock state |
| cfg_err_o | output | 1 | Validity error flag |
| slot_err_o | output | 1 | Slot write error flag |
| opt_live_o | output | 224 | Live values of the writable slots, slot 0 in the low bits |

## Verification
Two functions can meet in one CTRL write: setting the option lock and requesting a reload. The bench opens both locks and writes CTRL with bits 1 and 3 together. It then checks that busy rises and lasts NUM_SLOTS+1 cycles, that an edit made before the write is replaced by the committed image, and that the option lock reads as set. The same write pattern sent while the option lock is already set must leave busy low and the live value untouched.

// File: rtl/optl_pkg.sv
package optl_pkg;

  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd1;
  localparam logic [ADDR_W-1:0] A_MKEY = 3'd2;
  localparam logic [ADDR_W-1:0] A_OKEY = 3'd3;
  localparam logic [ADDR_W-1:0] A_SEL  = 3'd4;
  localparam logic [ADDR_W-1:0] A_LIVE = 3'd5;
  localparam logic [ADDR_W-1:0] A_RAWV = 3'd6;
  localparam logic [ADDR_W-1:0] A_RAWC = 3'd7;

  localparam logic [31:0] MAIN_KEY_A = 32'h4567_0123;
  localparam logic [31:0] MAIN_KEY_B = 32'hCDEF_89AB;
  localparam logic [31:0] OPT_KEY_A  = 32'h0819_2A3B;
  localparam logic [31:0] OPT_KEY_B  = 32'h4C5D_6E7F;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_LOAD = 2'd1,
    SQ_PROG = 2'd2,
    SQ_HOLD = 2'd3
  } seq_state_e;

endpackage

// File: rtl/optl_key_gate.sv
module optl_key_gate #(
  parameter int          DATA_W = 32,
  parameter logic [31:0] KEY_A  = 32'h0,
  parameter logic [31:0] KEY_B  = 32'h0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              enable,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] key_data,
  input  logic              relock,
  output logic              locked_o
);

  logic locked_q;
  logic armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      locked_q <= 1'b1;
      armed_q  <= 1'b0;
    end else if (relock) begin
      locked_q <= 1'b1;
      armed_q  <= 1'b0;
    end else if (!enable) begin
      armed_q <= 1'b0;
    end else if (locked_q && key_wr) begin
      if (!armed_q && key_data == DATA_W'(KEY_A)) begin
        armed_q <= 1'b1;
      end else if (armed_q && key_data == DATA_W'(KEY_B)) begin
        armed_q  <= 1'b0;
        locked_q <= 1'b0;
      end else begin
        armed_q <= 1'b0;
      end
    end
  end

  assign locked_o = locked_q;

  AST_OPEN_NEEDS_SECOND_KEY: assert property (@(posedge clk) disable iff (rst)
    $fell(locked_q) |-> $past(key_wr && enable && key_data == DATA_W'(KEY_B))); // R2

  AST_RELOCK_TAKES: assert property (@(posedge clk) disable iff (rst)
    relock |=> locked_q); // R4

endmodule

// File: rtl/optl_image_store.sv
module optl_image_store #(
  parameter int          NUM_SLOTS = 16,
  parameter int          DATA_W    = 32,
  parameter logic [31:0] INIT_SEED = 32'h0,
  parameter logic [15:0] BAD_MASK  = 16'h0,
  localparam int         SLOT_W    = $clog2(NUM_SLOTS)
) (
  input  logic                clk,
  input  logic                we,
  input  logic [SLOT_W-1:0]   waddr,
  input  logic [2*DATA_W-1:0] wdata,
  input  logic [SLOT_W-1:0]   raddr,
  output logic [2*DATA_W-1:0] rdata_o
);

  logic [2*DATA_W-1:0] mem [NUM_SLOTS];

  // Factory image: inverse word in the upper half, value word in the lower.
  initial begin
    for (int i = 0; i < NUM_SLOTS; i++) begin
      logic [DATA_W-1:0] v;
      v = DATA_W'(INIT_SEED) ^ (DATA_W'(i) * DATA_W'(32'h1111_1111));
      if (i < 16 && BAD_MASK[i % 16]) mem[i] = {v, v};
      else                           mem[i] = {~v, v};
    end
  end

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata_o <= mem[raddr];
  end

endmodule

// File: rtl/optl_sequencer.sv
module optl_sequencer
  import optl_pkg::*;
#(
  parameter int NUM_SLOTS     = 16,
  parameter int NUM_WR        = 7,
  parameter int COMMIT_CYCLES = 32,
  localparam int SLOT_W       = $clog2(NUM_SLOTS),
  localparam int HOLD_W       = $clog2(COMMIT_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit_req,
  input  logic              reload_req,
  input  logic [SLOT_W-1:0] sel,
  output logic              busy_o,
  output logic              mem_we_o,
  output logic [SLOT_W-1:0] mem_waddr_o,
  output logic [SLOT_W-1:0] mem_raddr_o,
  output logic              load_en_o,
  output logic [SLOT_W-1:0] load_slot_o
);

  seq_state_e          state_q;
  logic [SLOT_W:0]     ld_idx_q;
  logic                ld_pend_q;
  logic [SLOT_W-1:0]   ld_slot_q;
  logic [SLOT_W-1:0]   pg_idx_q;
  logic [HOLD_W-1:0]   hold_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= SQ_LOAD;
      ld_idx_q  <= '0;
      ld_pend_q <= 1'b0;
      ld_slot_q <= '0;
      pg_idx_q  <= '0;
      hold_q    <= '0;
    end else begin
      unique case (state_q)
        SQ_IDLE: begin
          ld_pend_q <= 1'b0;
          if (commit_req) begin
            state_q  <= SQ_PROG;
            pg_idx_q <= '0;
          end else if (reload_req) begin
            state_q  <= SQ_LOAD;
            ld_idx_q <= '0;
          end
        end
        SQ_LOAD: begin
          ld_pend_q <= (ld_idx_q < (SLOT_W+1)'(NUM_SLOTS));
          ld_slot_q <= ld_idx_q[SLOT_W-1:0];
          if (ld_idx_q == (SLOT_W+1)'(NUM_SLOTS)) state_q <= SQ_IDLE;
          else                                    ld_idx_q <= ld_idx_q + 1'b1;
        end
        SQ_PROG: begin
          if (pg_idx_q == SLOT_W'(NUM_WR - 1)) begin
            state_q <= SQ_HOLD;
            hold_q  <= HOLD_W'(COMMIT_CYCLES - 1);
          end else begin
            pg_idx_q <= pg_idx_q + 1'b1;
          end
        end
        SQ_HOLD: begin
          if (hold_q == '0) state_q <= SQ_IDLE;
          else              hold_q  <= hold_q - 1'b1;
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign busy_o      = (state_q != SQ_IDLE);
  assign mem_we_o    = (state_q == SQ_PROG);
  assign mem_waddr_o = pg_idx_q;
  assign mem_raddr_o = (state_q == SQ_LOAD) ? ld_idx_q[SLOT_W-1:0] : sel;
  assign load_en_o   = ld_pend_q;
  assign load_slot_o = ld_slot_q;

  AST_COMMIT_RAISES_BUSY: assert property (@(posedge clk) disable iff (rst)
    (commit_req && !busy_o) |=> (busy_o && mem_we_o)); // R7

  AST_RELOAD_RAISES_BUSY: assert property (@(posedge clk) disable iff (rst)
    (reload_req && !commit_req && !busy_o) |=> busy_o); // R8

  AST_STORE_ONLY_WRITABLE: assert property (@(posedge clk) disable iff (rst)
    mem_we_o |-> (mem_waddr_o < SLOT_W'(NUM_WR))); // R7

endmodule

// File: rtl/opt_lock_load_unit.sv
module opt_lock_load_unit
  import optl_pkg::*;
#(
  parameter int          NUM_SLOTS     = 16,
  parameter int          NUM_WR        = 7,
  parameter int          DATA_W        = 32,
  parameter int          COMMIT_CYCLES = 32,
  parameter logic [31:0] INIT_SEED     = 32'h5A3C_0000,
  parameter logic [15:0] BAD_MASK      = 16'h0000,
  localparam int         SLOT_W        = $clog2(NUM_SLOTS)
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [2:0]               bus_addr,
  input  logic                     bus_wr,
  input  logic [31:0]              bus_wdata,
  input  logic                     bus_rd,
  output logic [31:0]              bus_rdata,
  input  logic                     op_suspended_i,
  output logic                     busy_o,
  output logic                     main_lock_o,
  output logic                     opt_lock_o,
  output logic                     cfg_err_o,
  output logic                     slot_err_o,
  output logic [NUM_WR*DATA_W-1:0] opt_live_o
);

  logic                main_locked, opt_locked, busy;
  logic                ctrl_wr, stat_wr, data_wr;
  logic                commit_req, reload_req;
  logic                live_wr_ok, slot_bad_wr;
  logic [SLOT_W-1:0]   sel_q;
  logic                mem_we, load_en;
  logic [SLOT_W-1:0]   mem_waddr, mem_raddr, load_slot;
  logic [2*DATA_W-1:0] mem_q, mem_wdata;
  logic [DATA_W-1:0]   live_q [NUM_SLOTS];
  logic                pair_ok;
  logic                cfg_err_q, slot_err_q;
  logic [31:0]         rdata_q;

  assign ctrl_wr = bus_wr && bus_addr == A_CTRL;
  assign stat_wr = bus_wr && bus_addr == A_STAT;
  assign data_wr = bus_wr && bus_addr == A_LIVE;

  // Lock state before this write decides acceptance.
  assign commit_req  = ctrl_wr && bus_wdata[2] && !opt_locked && !busy && !op_suspended_i;
  assign reload_req  = ctrl_wr && bus_wdata[3] && !opt_locked && !busy;
  assign live_wr_ok  = data_wr && !opt_locked && !busy;
  assign slot_bad_wr = live_wr_ok && (sel_q >= SLOT_W'(NUM_WR));

  optl_key_gate #(.DATA_W(32), .KEY_A(MAIN_KEY_A), .KEY_B(MAIN_KEY_B)) main_gate_i (
    .clk      (clk),
    .rst      (rst),
    .enable   (1'b1),
    .key_wr   (bus_wr && bus_addr == A_MKEY),
    .key_data (bus_wdata),
    .relock   (ctrl_wr && bus_wdata[0]),
    .locked_o (main_locked)
  );

  optl_key_gate #(.DATA_W(32), .KEY_A(OPT_KEY_A), .KEY_B(OPT_KEY_B)) opt_gate_i (
    .clk      (clk),
    .rst      (rst),
    .enable   (!main_locked),
    .key_wr   (bus_wr && bus_addr == A_OKEY),
    .key_data (bus_wdata),
    .relock   (ctrl_wr && (bus_wdata[0] || bus_wdata[1])),
    .locked_o (opt_locked)
  );

  optl_sequencer #(
    .NUM_SLOTS(NUM_SLOTS), .NUM_WR(NUM_WR), .COMMIT_CYCLES(COMMIT_CYCLES)
  ) seq_i (
    .clk         (clk),
    .rst         (rst),
    .commit_req  (commit_req),
    .reload_req  (reload_req),
    .sel         (sel_q),
    .busy_o      (busy),
    .mem_we_o    (mem_we),
    .mem_waddr_o (mem_waddr),
    .mem_raddr_o (mem_raddr),
    .load_en_o   (load_en),
    .load_slot_o (load_slot)
  );

  assign mem_wdata = {~live_q[mem_waddr], live_q[mem_waddr]};

  optl_image_store #(
    .NUM_SLOTS(NUM_SLOTS), .DATA_W(DATA_W), .INIT_SEED(INIT_SEED), .BAD_MASK(BAD_MASK)
  ) store_i (
    .clk     (clk),
    .we      (mem_we),
    .waddr   (mem_waddr),
    .wdata   (mem_wdata),
    .raddr   (mem_raddr),
    .rdata_o (mem_q)
  );

  assign pair_ok = (mem_q[2*DATA_W-1:DATA_W] == ~mem_q[DATA_W-1:0]);

  always_ff @(posedge clk) begin
    if (rst) sel_q <= '0;
    else if (bus_wr && bus_addr == A_SEL) sel_q <= bus_wdata[SLOT_W-1:0];
  end

  // Live option registers: writable slots take bus writes, all take loads.
  for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_live
    logic hit_load;
    assign hit_load = load_en && load_slot == SLOT_W'(g);
    if (g < NUM_WR) begin : g_wr
      always_ff @(posedge clk) begin
        if (rst)                                   live_q[g] <= '1;
        else if (hit_load)                         live_q[g] <= pair_ok ? mem_q[DATA_W-1:0] : '1;
        else if (live_wr_ok && sel_q == SLOT_W'(g)) live_q[g] <= bus_wdata[DATA_W-1:0];
      end
      assign opt_live_o[g*DATA_W +: DATA_W] = live_q[g];
    end else begin : g_ro
      always_ff @(posedge clk) begin
        if (rst)           live_q[g] <= '1;
        else if (hit_load) live_q[g] <= pair_ok ? mem_q[DATA_W-1:0] : '1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_err_q  <= 1'b0;
      slot_err_q <= 1'b0;
    end else begin
      if (load_en && !pair_ok)          cfg_err_q <= 1'b1;
      else if (stat_wr && bus_wdata[1]) cfg_err_q <= 1'b0;
      if (slot_bad_wr)                  slot_err_q <= 1'b1;
      else if (stat_wr && bus_wdata[2]) slot_err_q <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_q <= '0;
    end else if (bus_rd) begin
      unique case (bus_addr)
        A_CTRL:  rdata_q <= {30'd0, opt_locked, main_locked};
        A_STAT:  rdata_q <= {29'd0, slot_err_q, cfg_err_q, busy};
        A_SEL:   rdata_q <= 32'(sel_q);
        A_LIVE:  rdata_q <= 32'(live_q[sel_q]);
        A_RAWV:  rdata_q <= 32'(mem_q[DATA_W-1:0]);
        A_RAWC:  rdata_q <= 32'(mem_q[2*DATA_W-1:DATA_W]);
        default: rdata_q <= '0;
      endcase
    end
  end

  assign bus_rdata   = rdata_q;
  assign busy_o      = busy;
  assign main_lock_o = main_locked;
  assign opt_lock_o  = opt_locked;
  assign cfg_err_o   = cfg_err_q;
  assign slot_err_o  = slot_err_q;

  AST_MAIN_IMPLIES_OPT: assert property (@(posedge clk) disable iff (rst)
    main_locked |-> opt_locked); // R4

  AST_LOCKED_LIVE_STABLE: assert property (@(posedge clk) disable iff (rst)
    (opt_locked && !load_en) |=> $stable(opt_live_o)); // R6

  AST_BAD_PAIR_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (load_en && mem_q[2*DATA_W-1:DATA_W] != ~mem_q[DATA_W-1:0]) |=> cfg_err_q); // R9

  AST_RO_WRITE_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (data_wr && !opt_locked && !busy && sel_q >= SLOT_W'(NUM_WR)) |=> slot_err_q); // R6

endmodule

// File: tb/opt_lock_load_unit_tb_top.sv
module opt_lock_load_unit_tb_top;

  localparam int          NS    = 16;
  localparam int          NW    = 7;
  localparam int          HOLD  = 20;
  localparam logic [31:0] SEED  = 32'h5A3C_0000;
  localparam logic [15:0] BAD   = 16'h8000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic        bus_rd = 1'b0;
  logic [31:0] bus_rdata;
  logic        susp = 1'b0;
  logic        busy, mlock, olock, cerr, serr;
  logic [NW*32-1:0] live;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #4 clk = ~clk;

  opt_lock_load_unit #(
    .NUM_SLOTS(NS), .NUM_WR(NW), .DATA_W(32), .COMMIT_CYCLES(HOLD),
    .INIT_SEED(SEED), .BAD_MASK(BAD)
  ) dut_i (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
    .bus_rd(bus_rd), .bus_rdata(bus_rdata), .op_suspended_i(susp), .busy_o(busy),
    .main_lock_o(mlock), .opt_lock_o(olock), .cfg_err_o(cerr), .slot_err_o(serr),
    .opt_live_o(live)
  );

  function automatic logic [31:0] img(int i);
    return SEED ^ (32'(i) * 32'h1111_1111);
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(logic [2:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic rd_live(int s, output logic [31:0] d);
    wr(3'd4, 32'(s));
    rd(3'd5, d);
  endtask

  task automatic rd_raw(int s, output logic [31:0] v, output logic [31:0] c);
    wr(3'd4, 32'(s));
    @(negedge clk);
    rd(3'd6, v);
    rd(3'd7, c);
  endtask

  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 1000) begin
      n++;
      @(negedge clk);
    end
  endtask

  task automatic t_reset();
    int n;
    logic [31:0] d;
    repeat (4) @(negedge clk);
    chk("R1 main lock in reset", 32'(mlock), 1);
    chk("R1 opt lock in reset", 32'(olock), 1);
    chk("R1 busy in reset", 32'(busy), 1);
    rst = 1'b0;
    busy_len(n);
    chk("R1 boot load length", 32'(n), NS + 1);
    chk("R9 validity flag after boot", 32'(cerr), 1);
    rd_live(0, d);  chk("R1 slot0 loaded", d, img(0));
    rd_live(6, d);  chk("R1 slot6 loaded", d, img(6));
    rd_live(13, d); chk("R1 slot13 loaded", d, img(13));
    rd_live(15, d); chk("R9 bad slot15 all ones", d, 32'hFFFF_FFFF);
    chk("R1 opt_live_o slot4", live[4*32 +: 32], img(4));
  endtask

  task automatic t_keys();
    logic [31:0] d;
    wr(3'd3, 32'h0819_2A3B); wr(3'd3, 32'h4C5D_6E7F);
    chk("R3 opt keys while main locked", 32'(olock), 1);
    wr(3'd2, 32'h0000_1234); wr(3'd2, 32'hCDEF_89AB);
    chk("R2 wrong first key", 32'(mlock), 1);
    wr(3'd2, 32'h4567_0123); wr(3'd2, 32'h1111_1111); wr(3'd2, 32'hCDEF_89AB);
    chk("R2 broken sequence", 32'(mlock), 1);
    wr(3'd2, 32'h4567_0123); wr(3'd2, 32'hCDEF_89AB);
    chk("R2 main unlocked", 32'(mlock), 0);
    chk("R3 opt still locked", 32'(olock), 1);
    wr(3'd3, 32'h0819_2A3B); wr(3'd3, 32'h4C5D_6E7F);
    chk("R3 opt unlocked", 32'(olock), 0);
    rd(3'd0, d);
    chk("R3 CTRL readback", d, 32'h0);
  endtask

  task automatic t_live_edit();
    logic [31:0] d;
    wr(3'd1, 32'h2);
    chk("R10 validity flag cleared", 32'(cerr), 0);
    wr(3'd4, 32'd2); wr(3'd5, 32'hCAFE_F00D);
    rd(3'd5, d);
    chk("R5 slot2 readback", d, 32'hCAFE_F00D);
    chk("R5 slot2 on opt_live_o", live[2*32 +: 32], 32'hCAFE_F00D);
    wr(3'd4, 32'd14); wr(3'd5, 32'h0000_0001);
    chk("R6 slot error raised", 32'(serr), 1);
    rd(3'd5, d);
    chk("R6 read-only slot14 unchanged", d, img(14));
    wr(3'd1, 32'h4);
    chk("R10 slot error cleared", 32'(serr), 0);
  endtask

  task automatic t_commit();
    int n;
    logic [31:0] v, c;
    susp = 1'b1;
    wr(3'd0, 32'h4);
    chk("R7 commit blocked by suspend", 32'(busy), 0);
    susp = 1'b0;
    wr(3'd0, 32'h4);
    busy_len(n);
    chk("R7 commit busy length", 32'(n), NW + HOLD);
    rd_raw(2, v, c);
    chk("R7 stored value slot2", v, 32'hCAFE_F00D);
    chk("R7 stored inverse slot2", c, ~32'hCAFE_F00D);
    rd_raw(5, v, c);
    chk("R7 stored inverse slot5", c, ~img(5));
  endtask

  task automatic t_locked();
    int n;
    logic [31:0] d;
    wr(3'd4, 32'd2); wr(3'd5, 32'h1111_2222);
    wr(3'd0, 32'h2);
    chk("R4 opt lock set by bit1", 32'(olock), 1);
    chk("R4 main stays open", 32'(mlock), 0);
    wr(3'd4, 32'd1); wr(3'd5, 32'h0000_DEAD);
    rd(3'd5, d);
    chk("R6 locked write ignored", d, img(1));
    chk("R6 locked write no flag", 32'(serr), 0);
    wr(3'd0, 32'h8);
    busy_len(n);
    chk("R8 reload ignored when locked", 32'(n), 0);
    chk("R8 slot2 kept edit", live[2*32 +: 32], 32'h1111_2222);
  endtask

  task automatic t_lock_with_reload();
    int n;
    wr(3'd3, 32'h0819_2A3B); wr(3'd3, 32'h4C5D_6E7F);
    chk("R3 opt reopened", 32'(olock), 0);
    wr(3'd0, 32'hA);
    busy_len(n);
    chk("R11 reload ran", 32'(n), NS + 1);
    chk("R8 R11 slot2 from image", live[2*32 +: 32], 32'hCAFE_F00D);
    chk("R11 opt lock set", 32'(olock), 1);
    chk("R9 validity flag again", 32'(cerr), 1);
    wr(3'd0, 32'h1);
    chk("R4 main relocked", 32'(mlock), 1);
    chk("R4 opt relocked", 32'(olock), 1);
  endtask

  initial begin
    t_reset();
    t_keys();
    t_live_edit();
    t_commit();
    t_locked();
    t_lock_with_reload();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule